// File: doc/BRIEF.md
# Daisy-Chainable SPI Register Slave

This block is an SPI slave that serves a small register file and can sit in a chain of identical slaves, with each one's serial output wired to the next one's serial input. While the select line is low, the block is a plain 16-stage delay line clocked by the serial clock. Every bit that enters on MOSI leaves on MISO sixteen serial clock edges later. A host can therefore address N chained slaves with one frame of 16×N bits, in which the word meant for the far end of the chain is sent first.

When select returns high, the block decodes the sixteen bits left in its shift word as its own command. The first bit is the read flag, seven address bits follow, and the last eight bits are data. A write stores the data byte. A read reloads the shift word with a response, so that the next frame carries it out on MISO. The serial inputs are brought into the system clock domain by a two-flop synchronizer. All edge detection runs on the system clock, so the serial clock must be several times slower than the system clock.

The address space holds 128 locations. Four registers are implemented, at addresses 0 to 3. All other locations read as zero.

Top module: `spi_chain_regslave`

## Requirements
- R1: After reset the shift word is all zeros, so MISO is 0 and the first frame shifts out sixteen zeros. Registers 0, 1, 2 and 3 reset to 0x10, 0x21, 0x32 and 0x43.
- R2: While select is low, each rising serial clock edge shifts MOSI into bit 0 of the 16-bit shift word, and MISO always shows bit 15. A bit is therefore presented on MISO for the 16th rising edge after the one that captured it.
- R3: The command word is read MSB first: bit 15 is the flag (1 = read), bits 14..8 are the address and bits 7..0 are data. A valid read reloads the shift word with {1, address, register value}, which the next frame shifts out MSB first.
- R4: A valid command with flag 0 stores bits 7..0 into the addressed register when select rises, and reloads the shift word with {0, address, 0x00}.
- R5: For a read, bits 7..0 of the command are ignored: no register changes, and the response does not depend on them.
- R6: Only the sixteen bits held when select rises are decoded. Earlier bits of a longer frame pass through to MISO without any effect, and nothing changes before select rises.
- R7: If the number of rising serial clock edges in a frame is zero or not a multiple of 16, the command is discarded. No register changes, and the shift word keeps the bits shifted into it.
- R8: Addresses 4 to 127 read as 0x00, and writes to them change nothing. A read of such an address returns {1, address, 0x00}.
- R9: Serial clock edges while select is high do not change the shift word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host or chain, idle low |
| ss_n_i | input | 1 | Active-low select; rising edge executes the command |
| mosi_i | input | 1 | Serial data in, sampled on rising serial clock |
| miso_o | output | 1 | Serial data out, bit 15 of the shift word |

## Verification
A shift word that slips by one position, or a lost serial clock edge, shows up on MISO in the very next frame: the response or the pass-through bits arrive one place early or late. A wrong frame-length count either executes a truncated command or drops a valid one. Both cases are seen at the latest in the following frame, through the echoed response and through a read-back of the register. A register bank that decodes the wrong address or keeps the read-flagged data byte only shows itself on a later read of that location, so the bench reads back every register it writes.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  data_t;

  // Flag bit is the first bit on the wire, i.e. the MSB of the frame.
  function automatic logic frame_is_read(frame_t f);
    return f[FRAME_W-1];
  endfunction

  function automatic addr_t frame_addr(frame_t f);
    return f[FRAME_W-2 -: ADDR_W];
  endfunction

  function automatic data_t frame_data(frame_t f);
    return f[DATA_W-1:0];
  endfunction

  function automatic frame_t make_frame(logic rd, addr_t a, data_t d);
    return {rd, a, d};
  endfunction

  // Reset value of implemented register idx: high nibble idx+1, low nibble idx.
  function automatic data_t reg_reset_value(int idx);
    return DATA_W'((idx + 1) * 16 + idx);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_chain_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shift_en,
  input  logic   bit_in,
  input  logic   restart,
  input  logic   load_en,
  input  frame_t load_word,
  output frame_t word_o,
  output logic   frame_ok_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  frame_t           word_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= load_word;
    end else if (shift_en) begin
      word_q <= {word_q[FRAME_W-2:0], bit_in};
    end
  end

  // Edge count modulo the frame length, plus a flag for "at least one edge".
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (shift_en) begin
      seen_q <= 1'b1;
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign word_o     = word_q;
  assign frame_ok_o = seen_q && (cnt_q == '0);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_chain_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  data_t wr_data,
  input  addr_t rd_addr,
  output data_t rd_data
);
  data_t reg_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= reg_reset_value(g);
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        reg_q[g] <= wr_data;
      end
    end
  end

  // Unimplemented locations fall through to zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = reg_q[i];
    end
  end
endmodule

// File: rtl/spi_chain_regslave.sv
module spi_chain_regslave
  import spi_chain_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ss_n_i,
  input  logic mosi_i,
  output logic miso_o
);
  // Synchronized inputs: {sck, ss_n, mosi}; idle sck low, select high.
  logic [2:0] sync_q;
  logic       sck_s, ss_n_s, mosi_s;
  logic       sck_prev_q, ss_prev_q;

  // Named events for the checker.
  logic   sck_rise, ss_rise, ss_active, shift_en;
  logic   frame_ok, cmd_valid, cmd_read, wr_en;
  frame_t cmd_word, resp_word;
  addr_t  cmd_addr;
  data_t  rd_data;

  spi_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sck_i, ss_n_i, mosi_i}),
    .q    (sync_q)
  );

  assign sck_s  = sync_q[2];
  assign ss_n_s = sync_q[1];
  assign mosi_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      ss_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      ss_prev_q  <= ss_n_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_prev_q;
  assign ss_rise   = ss_n_s & ~ss_prev_q;
  assign ss_active = ~ss_n_s;
  assign shift_en  = sck_rise & ss_active;

  assign cmd_valid = ss_rise & frame_ok;
  assign cmd_read  = frame_is_read(cmd_word);
  assign cmd_addr  = frame_addr(cmd_word);
  assign wr_en     = cmd_valid & ~cmd_read;
  assign resp_word = cmd_read ? make_frame(1'b1, cmd_addr, rd_data)
                              : make_frame(1'b0, cmd_addr, '0);

  spi_frame_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .bit_in    (mosi_s),
    .restart   (~ss_active),
    .load_en   (cmd_valid),
    .load_word (resp_word),
    .word_o    (cmd_word),
    .frame_ok_o(frame_ok)
  );

  spi_reg_bank #(
    .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(cmd_addr),
    .wr_data(frame_data(cmd_word)),
    .rd_addr(cmd_addr),
    .rd_data(rd_data)
  );

  assign miso_o = cmd_word[FRAME_W-1];
endmodule

// File: rtl/spi_chain_checker.sv
module spi_chain_checker
  import spi_chain_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   sck_rise,
  input logic   ss_rise,
  input logic   ss_active,
  input logic   mosi_s,
  input logic   frame_ok,
  input logic   wr_en,
  input frame_t shift_word
);
  // R2: a serial edge inside a frame moves the word up by one place.
  p_delay_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && ss_active) |=>
      shift_word == {$past(shift_word[FRAME_W-2:0]), $past(mosi_s)});

  // R3: a valid read leaves {1, same address, ...} in the word.
  p_read_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_rise && frame_ok && shift_word[FRAME_W-1]) |=>
      (shift_word[FRAME_W-1] &&
       shift_word[FRAME_W-2 -: ADDR_W] == $past(shift_word[FRAME_W-2 -: ADDR_W])));

  // R4: a valid write leaves the echo {0, address, 0x00}.
  p_write_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_rise && frame_ok && !shift_word[FRAME_W-1]) |=>
      shift_word == {1'b0, $past(shift_word[FRAME_W-2 -: ADDR_W]), {DATA_W{1'b0}}});

  // R6: a register write only happens at a select rise after a whole frame.
  p_write_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ss_rise && frame_ok));

  // R7: a short or empty frame leaves the word untouched.
  p_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_rise && !frame_ok) |=> $stable(shift_word));

  // R9: with select high and no rise, the word holds.
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_active && !ss_rise) |=> $stable(shift_word));
endmodule

bind spi_chain_regslave spi_chain_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sck_rise  (sck_rise),
  .ss_rise   (ss_rise),
  .ss_active (ss_active),
  .mosi_s    (mosi_s),
  .frame_ok  (frame_ok),
  .wr_en     (wr_en),
  .shift_word(cmd_word)
);

// File: tb/test_spi_chain_regslave.sv
`timescale 1ns/1ps
module test_spi_chain_regslave;
  localparam int HALF = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic ss_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  always #2.5 clk = ~clk;  // 200 MHz

  spi_chain_regslave i_spi_chain_regslave (
    .clk   (clk),
    .rst_n (rst_n),
    .sck_i (sck),
    .ss_n_i(ss_n),
    .mosi_i(mosi),
    .miso_o(miso)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Scoreboard queues: expected MISO bit and the requirement it proves.
  logic  exp_bits[$];
  string exp_tags[$];
  event  sample_ev;

  // Bench-side model of the slave, from the requirements.
  logic [15:0] model_sh = 16'h0000;
  logic [7:0]  model_regs[4] = '{8'h10, 8'h21, 8'h32, 8'h43};
  int          model_cnt = 0;

  function automatic logic [7:0] model_read(logic [6:0] a);
    return (a < 7'd4) ? model_regs[a[1:0]] : 8'h00;
  endfunction

  function automatic void model_end_frame();
    logic       rd;
    logic [6:0] a;
    if (model_cnt == 0 || (model_cnt % 16) != 0) return;  // R7
    rd = model_sh[15];
    a  = model_sh[14:8];
    if (rd) begin
      model_sh = {1'b1, a, model_read(a)};
    end else begin
      if (a < 7'd4) model_regs[a[1:0]] = model_sh[7:0];
      model_sh = {1'b0, a, 8'h00};
    end
  endfunction

  // Monitor: pop one expectation per presented bit.
  initial begin
    forever begin
      @(sample_ev);
      if (exp_bits.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: miso=%b expected=<none>", miso);
      end else begin
        logic  e;
        string t;
        e = exp_bits.pop_front();
        t = exp_tags.pop_front();
        checks++;
        if (miso !== e) begin
          failures++;
          $display("FAIL %s: miso=%b expected=%b", t, miso, e);
        end
      end
    end
  end

  task automatic put_bit(input logic b, input string tag);
    @(negedge clk) mosi = b;
    repeat (HALF) @(negedge clk);
    exp_bits.push_back(model_sh[15]);
    exp_tags.push_back(tag);
    ->sample_ev;
    model_sh = {model_sh[14:0], b};
    model_cnt++;
    @(negedge clk) sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] bits, input int n, input string tag);
    @(negedge clk) ss_n = 1'b0;
    model_cnt = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) put_bit(bits[n-1-i], tag);
    repeat (HALF) @(negedge clk);
    ss_n = 1'b1;
    model_end_frame();
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic idle_sck_toggles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) mosi = ~mosi;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;  // R1: reset state on MISO
    if (miso !== 1'b0) begin
      failures++;
      $display("FAIL R1: miso=%b expected=0", miso);
    end

    // Command fields: {flag, A6..A0, D7..D0}
    run_frame({16'h0, 1'b1, 7'h01, 8'hFF}, 16, "R1");  // out: reset zeros
    run_frame({16'h0, 1'b0, 7'h02, 8'hA5}, 16, "R3");  // out: read reg1 = 0x21
    run_frame({16'h0, 1'b1, 7'h02, 8'h00}, 16, "R4");  // out: write echo
    run_frame({16'h0, 1'b1, 7'h00, 8'h5A}, 16, "R5");  // out: reg2 = 0xA5
    // 32-bit chain frame: write reg3 passes through, read reg0 executes.
    run_frame({1'b0, 7'h03, 8'h77, 1'b1, 7'h00, 8'hC3}, 32, "R2");
    run_frame({16'h0, 1'b1, 7'h03, 8'hFF}, 16, "R6");  // out: reg0 = 0x10
    run_frame({22'h0, 1'b0, 7'h01, 2'b01}, 10, "R6");  // out: reg3 = 0x43
    run_frame({16'h0, 1'b1, 7'h01, 8'h00}, 16, "R7");  // out: kept partial bits
    // Empty select pulse and serial edges with select high.
    @(negedge clk) ss_n = 1'b0;
    repeat (2 * HALF) @(negedge clk);
    ss_n = 1'b1;
    model_cnt = 0;
    model_end_frame();
    repeat (2 * HALF) @(negedge clk);
    idle_sck_toggles(5);
    run_frame({16'h0, 1'b0, 7'h40, 8'h99}, 16, "R9");  // out: reg1 = 0x21
    run_frame({16'h0, 1'b1, 7'h40, 8'h00}, 16, "R8");  // out: echo {0,40,00}
    run_frame({16'h0, 1'b1, 7'h7F, 8'h11}, 16, "R8");  // out: {1,40,00}
    run_frame({16'h0, 1'b0, 7'h00, 8'hFF}, 16, "R8");  // out: {1,7F,00}
    run_frame({16'h0, 1'b1, 7'h00, 8'hFF}, 16, "R4");  // out: echo {0,00,00}
    run_frame({16'h0, 16'hFFFF}, 16, "R4");            // out: reg0 = 0xFF

    if (exp_bits.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: pending=%0d expected=0", exp_bits.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule